// File: doc/BRIEF.md
# Token-Ring Depth-Chained FIFO

This block builds one deep first-in/first-out buffer out of several identical storage segments arranged in a ring. All segments see the same write strobe, write data, read strobe and reset. At any moment exactly one segment owns the write token and accepts writes, and exactly one segment owns the read token and supplies reads. When the write owner stores a word into its final physical slot, it passes the write token to its ring neighbour. The read token moves the same way when the read owner pops its final slot. Because both tokens travel the ring in the same order, words come out in the order they went in. The total capacity is `NUM_SEG * SEG_DEPTH` words.

Each segment has a first-position strap. The one segment with the strap tied low holds both tokens after reset. The block is synchronous and has an active-low reset. Reads work in first-word-fall-through mode: `rd_data` always shows the oldest stored word, and a read strobe removes that word. The chain-level empty flag comes from the current read owner, and the chain-level full flag comes from the current write owner.

Top module: `ring_fifo_chain`

## Requirements
- R1: A clock edge with `rst_n` low empties the chain. From the next cycle `empty`=1, `full`=0 and `rd_data`=0, and segment `FIRST_SEG` holds both tokens.
- R2: Words are read out in exactly the order in which they were accepted, across every segment boundary.
- R3: With no reads, `full` rises after exactly `NUM_SEG*SEG_DEPTH` accepted writes and not earlier.
- R4: A write strobe while `full` is high stores nothing, even when a read is accepted in the same cycle. The data read afterwards contains no such word.
- R5: A read strobe while `empty` is high removes nothing. A write in the same cycle is still accepted.
- R6: Exactly one segment holds the write token at all times. Back-to-back writes across a segment boundary lose no word.
- R7: Exactly one segment holds the read token at all times. Back-to-back reads across a segment boundary skip no word.
- R8: The tokens wrap from the last segment back to the first. A stream longer than the total capacity keeps its order.
- R9: A read and a write accepted together while the chain is neither empty nor full leave the occupancy unchanged, so both flags stay low.
- R10: Flags are registered results. `empty` falls in the cycle after the first write into an empty chain, and `full` falls in the cycle after a read from a full chain.
- R11: While not empty, `rd_data` shows the oldest word and holds it until a read is accepted. While empty, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, removes the word on `rd_data` |
| rd_data | output | DATA_W | Oldest stored word, 0 when empty |
| empty | output | 1 | Chain holds no word |
| full | output | 1 | Chain holds `NUM_SEG*SEG_DEPTH` words |

## Verification
If a token is lost or duplicated at a handoff, the ports show it within one segment's worth of traffic. Either a word is missing or repeated, or a stale word appears on `rd_data` right after the boundary read. Either way it shows up as soon as that word reaches the head. A wrong per-segment fill count shows up as `full` rising at the wrong write count, or `empty` rising with words still pending. Both surface in the cycle after the offending strobe. So the directed sequences cross every boundary back-to-back and wrap the ring several times, and they compare every cycle against a queue model.

// File: rtl/chain_pkg.sv
// Shared helpers for the token-ring FIFO chain.
// Assumes segment indices run 0..n-1 around the ring.
package chain_pkg;
    // Ring predecessor of a segment: the one whose token handoff it receives.
    function automatic int prev_seg(int idx, int n);
        return (idx == 0) ? (n - 1) : (idx - 1);
    endfunction
endpackage

// File: rtl/seg_store.sv
// Storage array of one segment: one synchronous write port, one asynchronous read port.
// Assumes the caller never writes and reads the same slot in a way that relies on bypass.
module seg_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a word on an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chain_seg.sv
// One FIFO segment of the ring. It writes only while it owns the write token and reads
// only while it owns the read token. It emits a same-cycle handoff pulse when it uses
// its last physical slot. Assumes the handoff inputs come from the ring predecessor.
module chain_seg #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             wtok_in,
    input  logic             rtok_in,
    output logic             wtok_out,
    output logic             rtok_out,
    output logic             wtok_held,
    output logic             rtok_held,
    output logic             seg_empty,
    output logic             seg_full,
    output logic [WIDTH-1:0] seg_q
);
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    fill;
    logic             wtok, rtok;
    logic             do_wr, do_rd, wlast, rlast, is_empty, is_full;
    logic [WIDTH-1:0] ram_q;

    assign is_empty = (fill == '0);
    assign is_full  = (fill == CW'(DEPTH));
    assign do_wr    = wtok & wr_en & ~is_full;
    assign do_rd    = rtok & rd_en & ~is_empty;
    assign wlast    = (wptr == AW'(DEPTH - 1));
    assign rlast    = (rptr == AW'(DEPTH - 1));
    assign wtok_out = do_wr & wlast;
    assign rtok_out = do_rd & rlast;

    // Token ownership: the strap chooses the owner at reset; handoffs move it around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wtok <= ~first_n;
            rtok <= ~first_n;
        end else begin
            wtok <= (wtok & ~wtok_out) | wtok_in;
            rtok <= (rtok & ~rtok_out) | rtok_in;
        end
    end

    // Write pointer: advance on each stored word, wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     wptr <= '0;
        else if (do_wr) wptr <= wlast ? '0 : wptr + AW'(1);
    end

    // Read pointer: advance on each removed word, wrap after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     rptr <= '0;
        else if (do_rd) rptr <= rlast ? '0 : rptr + AW'(1);
    end

    // Occupancy of this segment.
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= '0;
        else begin
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    seg_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (ram_q)
    );

    assign wtok_held = wtok;
    assign rtok_held = rtok;
    assign seg_empty = rtok & is_empty;
    assign seg_full  = wtok & is_full;
    assign seg_q     = (rtok & ~is_empty) ? ram_q : '0;
endmodule

// File: rtl/chain_merge.sv
// Merges per-segment outputs into chain outputs. Assumes every segment that does not own
// the relevant token drives zero on its flag and data outputs, so a plain OR selects the owner.
module chain_merge #(
    parameter int N     = 3,
    parameter int WIDTH = 9
) (
    input  logic [N-1:0]            seg_empty,
    input  logic [N-1:0]            seg_full,
    input  logic [N-1:0][WIDTH-1:0] seg_q,
    output logic                    empty,
    output logic                    full,
    output logic [WIDTH-1:0]        q
);
    // OR together the data of all segments; only the read owner is nonzero.
    always_comb begin
        q = '0;
        for (int i = 0; i < N; i++) q = q | seg_q[i];
    end

    assign empty = |seg_empty;
    assign full  = |seg_full;
endmodule

// File: rtl/ring_fifo_chain.sv
// Deep FIFO made of NUM_SEG segments in a ring with separate write and read tokens.
// Segment FIRST_SEG is strapped as first. Assumes NUM_SEG >= 1, SEG_DEPTH >= 2.
module ring_fifo_chain #(
    parameter int NUM_SEG   = 3,
    parameter int SEG_DEPTH = 16,
    parameter int DATA_W    = 9,
    parameter int FIRST_SEG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    logic [NUM_SEG-1:0]             wtok_pass, rtok_pass, wtok_vec, rtok_vec;
    logic [NUM_SEG-1:0]             seg_empty, seg_full;
    logic [NUM_SEG-1:0][DATA_W-1:0] seg_q;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam int   PREV    = chain_pkg::prev_seg(g, NUM_SEG);
        localparam logic STRAP_N = (g == FIRST_SEG) ? 1'b0 : 1'b1;
        chain_seg #(.DEPTH(SEG_DEPTH), .WIDTH(DATA_W)) seg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .first_n   (STRAP_N),
            .wr_en     (wr_en),
            .wr_data   (wr_data),
            .rd_en     (rd_en),
            .wtok_in   (wtok_pass[PREV]),
            .rtok_in   (rtok_pass[PREV]),
            .wtok_out  (wtok_pass[g]),
            .rtok_out  (rtok_pass[g]),
            .wtok_held (wtok_vec[g]),
            .rtok_held (rtok_vec[g]),
            .seg_empty (seg_empty[g]),
            .seg_full  (seg_full[g]),
            .seg_q     (seg_q[g])
        );
    end

    chain_merge #(.N(NUM_SEG), .WIDTH(DATA_W)) merge_i (
        .seg_empty (seg_empty),
        .seg_full  (seg_full),
        .seg_q     (seg_q),
        .empty     (empty),
        .full      (full),
        .q         (rd_data)
    );
endmodule

// File: rtl/ring_fifo_chain_chk.sv
// Property checker for ring_fifo_chain, attached by bind. Observes ports and token vectors.
module ring_fifo_chain_chk #(
    parameter int N     = 3,
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             empty,
    input logic             full,
    input logic [WIDTH-1:0] rd_data,
    input logic [N-1:0]     wtok_vec,
    input logic [N-1:0]     rtok_vec
);
    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (empty && !full));
    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full));
    p_one_wtok_r6: assert property (@(posedge clk) disable iff (!rst_n) $countones(wtok_vec) == 1);
    p_one_rtok_r7: assert property (@(posedge clk) disable iff (!rst_n) $countones(rtok_vec) == 1);
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);
    p_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && wr_en && rd_en) |=> (!empty && !full));
    p_head_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en) |=> (!empty && $stable(rd_data)));
    p_zero_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == '0));
endmodule

bind ring_fifo_chain ring_fifo_chain_chk #(.N(NUM_SEG), .WIDTH(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .empty    (empty),
    .full     (full),
    .rd_data  (rd_data),
    .wtok_vec (wtok_vec),
    .rtok_vec (rtok_vec)
);

// File: tb/ring_fifo_chain_tb_top.sv
module ring_fifo_chain_tb_top;
    localparam int NSEG = 3;
    localparam int SDEP = 4;
    localparam int DW   = 9;
    localparam int CAP  = NSEG * SDEP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          empty, full;

    int            n_checks = 0;
    int            n_errors = 0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] next_val = 9'd1;

    always #2 clk = ~clk;

    ring_fifo_chain #(.NUM_SEG(NSEG), .SEG_DEPTH(SDEP), .DATA_W(DW), .FIRST_SEG(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the queue model (called away from the rising edge).
    task automatic check_all(input string tag);
        check_eq(tag, "empty", int'(empty), int'(model_q.size() == 0));
        check_eq(tag, "full", int'(full), int'(model_q.size() == CAP));
        check_eq(tag, "rd_data", int'(rd_data), (model_q.size() == 0) ? 0 : int'(model_q[0]));
    endtask

    // One clock cycle with the given strobes; starts and ends at a falling edge.
    task automatic step(input bit we, input bit re, input string tag);
        bit acc_w, acc_r;
        acc_w   = we && (model_q.size() < CAP);
        acc_r   = re && (model_q.size() > 0);
        wr_en   = we;
        rd_en   = re;
        wr_data = next_val;
        @(posedge clk);
        if (acc_r) void'(model_q.pop_front());
        if (acc_w) begin
            model_q.push_back(next_val);
            next_val = next_val + 9'd7;
        end
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check_all(tag);
    endtask

    // R1: reset from any state.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_q.delete();
        check_all("R1");
        rst_n = 1'b1;
    endtask

    // R3, R6, R10: fill with no reads, back-to-back across every boundary.
    task automatic t_fill();
        step(1'b1, 1'b0, "R10");
        for (int i = 1; i < CAP; i++) step(1'b1, 1'b0, "R3");
        check_eq("R3", "full after capacity", int'(full), 1);
    endtask

    // R4: writes while full, with and without a read.
    task automatic t_overflow();
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, "R4");
        step(1'b0, 1'b0, "R10");
    endtask

    // R2, R7: drain back-to-back across every boundary.
    task automatic t_drain();
        while (model_q.size() > 0) step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R7");
    endtask

    // R5: reads while empty, then read with a write in the same cycle.
    task automatic t_underflow();
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        step(1'b0, 1'b0, "R11");
        step(1'b0, 1'b0, "R11");
        step(1'b0, 1'b1, "R5");
    endtask

    // R8, R9: simultaneous traffic at mid occupancy, wrapping the ring several times.
    task automatic t_stream();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R8");
        for (int i = 0; i < 4 * CAP; i++) step(1'b1, 1'b1, "R9");
        for (int i = 0; i < 20; i++) step(i % 3 != 0, i % 2 == 0, "R8");
        while (model_q.size() > 0) step(1'b0, 1'b1, "R8");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_fill();
        t_overflow();
        t_drain();
        t_underflow();
        t_stream();
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R6");
        t_reset();
        t_fill();
        t_drain();
        finish_run();
    end
endmodule